// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

The block turns a 75 kHz reference strobe into a square-wave buzzer signal on a single output pin. Four tone pitches (0.75, 1, 1.5 and 3 kHz) are each made by dividing the strobe down, and four gating envelopes decide when the tone reaches the pin. The envelopes are steady tone, a single 100 ms burst, a 10 Hz on/off pattern, and that 10 Hz pattern sounding for half a second out of every second.

The pin is shared with a general-purpose port bit. While the buzzer enable is low the pin carries the port value and the tone engine is held cleared. Control is through plain level and pulse inputs: pitch code, envelope code, a start pulse and a stop pulse. A status output reports that a single burst has run to its end. The block has no data stream, so there is no valid/ready interface and no back-pressure.

Top module: `buzzer_tone_gen`

## Requirements
- R1: After reset the engine is idle with the done flag low, and with the enable low the pin equals `port_data_i`.
- R2: Pitch code 0/1/2/3 gives a tone period of 100/75/50/25 reference ticks. In each period the tone is low for the first ceil(period/2) ticks (50/38/25/13) and high for the rest.
- R3: Envelope code 0 passes the tone to the pin without interruption while running.
- R4: Envelope code 1 passes the tone for 7500 ticks after start. The engine then stops, the pin goes low and `shot_done_o` goes high on the same edge.
- R5: Envelope code 2 passes the tone for 3750 ticks, blocks it for 3750 ticks, and repeats.
- R6: Envelope code 3 applies the R5 pattern for 37500 ticks and then keeps the pin low for 37500 ticks, repeating with a 75000-tick period.
- R7: A change of pitch or envelope code clears all tone and envelope counters. The pin is low in the cycle after the change.
- R8: With the enable low, the counters are held cleared and the pin follows `port_data_i`. After the enable rises, the tone starts from the beginning of its low half.
- R9: A stop pulse halts the engine and holds the pin low. When start and stop are pulsed in the same cycle, stop wins.
- R10: `shot_done_o` is cleared by a start pulse or by a change of pitch or envelope code.
- R11: Counters advance only in cycles with `tick_i` high. Without ticks the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe at the 75 kHz reference rate |
| buz_en_i | input | 1 | 1: pin carries buzzer; 0: pin carries port bit |
| freq_sel_i | input | 2 | Pitch code (R2) |
| mode_sel_i | input | 2 | Envelope code (R3 to R6) |
| start_i | input | 1 | Start pulse, restarts counters |
| stop_i | input | 1 | Stop pulse |
| port_data_i | input | 1 | General-purpose port value for the shared pin |
| pin_o | output | 1 | Shared output pin |
| shot_done_o | output | 1 | Single burst finished |

## Verification
The hardest situation to reach is the nested envelope. The silent half-second only shows after the 10 Hz gating has run its full 37500 ticks, and the seam between cycles only after 75000 ticks. The stimulus therefore strobes `tick_i` every clock with the default rate and runs one full second plus a margin. A behavioural model compares the pin on every clock across that seam. The end of the single burst is driven the same way, and a pitch change is applied exactly while the tone is high, so that the restart to low is seen directly.

// File: rtl/buz_pkg.sv
package buz_pkg;

  typedef enum logic [1:0] {
    GATE_CONT = 2'd0,
    GATE_SHOT = 2'd1,
    GATE_10HZ = 2'd2,
    GATE_1HZ  = 2'd3
  } gate_mode_e;

  localparam int NUM_PITCH = 4;

  // Full tone period in reference ticks for a pitch code.
  function automatic int tone_period(input int tick_hz, input int code);
    case (code)
      0:       return tick_hz / 750;
      1:       return tick_hz / 1000;
      2:       return tick_hz / 1500;
      default: return tick_hz / 3000;
    endcase
  endfunction

endpackage

// File: rtl/buz_tone_div.sv
module buz_tone_div
  import buz_pkg::*;
#(
  parameter int TICK_HZ = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] freq_sel,
  output logic       tone_hi
);
  localparam int MAXP = TICK_HZ / 750;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] per_tab [NUM_PITCH];
  logic [CW-1:0] low_tab [NUM_PITCH];
  logic [CW-1:0] cnt;

  for (genvar k = 0; k < NUM_PITCH; k++) begin : g_pitch
    localparam int P = tone_period(TICK_HZ, k);
    assign per_tab[k] = CW'(P);
    assign low_tab[k] = CW'((P + 1) / 2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (adv) cnt <= (cnt == per_tab[freq_sel] - CW'(1)) ? '0 : cnt + CW'(1);
  end

  assign tone_hi = (cnt >= low_tab[freq_sel]);

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_tab[freq_sel]);
  a_r7_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tone_hi);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(cnt));
endmodule

// File: rtl/buz_gate_seq.sv
module buz_gate_seq
  import buz_pkg::*;
#(
  parameter int TICK_HZ = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  gate_mode_e mode,
  output logic       gate_on,
  output logic       shot_last
);
  localparam int H10  = TICK_HZ / 20;
  localparam int H1   = TICK_HZ / 2;
  localparam int SHOT = TICK_HZ / 10;
  localparam int W10  = $clog2(2 * H10);
  localparam int W1   = $clog2(2 * H1);

  logic [W10-1:0] g10;
  logic [W1-1:0]  g1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      g10 <= '0;
      g1  <= '0;
    end else if (adv) begin
      g10 <= (g10 == W10'(2 * H10 - 1)) ? '0 : g10 + W10'(1);
      g1  <= (g1  == W1'(2 * H1 - 1))   ? '0 : g1 + W1'(1);
    end
  end

  always_comb begin
    case (mode)
      GATE_CONT: gate_on = 1'b1;
      GATE_SHOT: gate_on = 1'b1;
      GATE_10HZ: gate_on = (g10 < W10'(H10));
      default:   gate_on = (g1 < W1'(H1)) && (g10 < W10'(H10));
    endcase
  end

  assign shot_last = (mode == GATE_SHOT) && (g1 == W1'(SHOT - 1));

  a_r5_fast_range: assert property (@(posedge clk) disable iff (!rst_n)
    g10 < W10'(2 * H10));
  a_r6_windows_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (g1 == '0) |-> (g10 == '0));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> ($stable(g1) && $stable(g10)));
endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen
  import buz_pkg::*;
#(
  parameter int TICK_HZ = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       buz_en_i,
  input  logic [1:0] freq_sel_i,
  input  logic [1:0] mode_sel_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       port_data_i,
  output logic       pin_o,
  output logic       shot_done_o
);
  logic [1:0] freq_q;
  logic [1:0] mode_q;
  logic       running_q;
  logic       done_q;
  logic       cfg_chg, restart, adv, fire, clr;
  logic       gate_on, shot_last, tone_hi;

  assign cfg_chg = (freq_sel_i != freq_q) || (mode_sel_i != mode_q);
  assign restart = start_i | stop_i | cfg_chg | !buz_en_i;
  assign adv     = tick_i & running_q & buz_en_i & !restart;
  assign fire    = adv & shot_last;
  assign clr     = restart | fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q    <= '0;
      mode_q    <= '0;
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      freq_q <= freq_sel_i;
      mode_q <= mode_sel_i;
      if (stop_i)       running_q <= 1'b0;
      else if (start_i) running_q <= 1'b1;
      else if (fire)    running_q <= 1'b0;
      if (start_i || cfg_chg) done_q <= 1'b0;
      else if (fire)          done_q <= 1'b1;
    end
  end

  buz_tone_div #(.TICK_HZ(TICK_HZ)) u_tone (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .freq_sel(freq_q), .tone_hi(tone_hi)
  );

  buz_gate_seq #(.TICK_HZ(TICK_HZ)) u_gate (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .mode(gate_mode_e'(mode_q)), .gate_on(gate_on), .shot_last(shot_last)
  );

  assign pin_o       = buz_en_i ? (running_q & gate_on & tone_hi) : port_data_i;
  assign shot_done_o = done_q;

  a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_q);
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !shot_done_o);
  a_r4_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_done_o) |-> (!running_q && $past(mode_q) == 2'd1));
  a_r7_change_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && buz_en_i) |=> (!pin_o || !buz_en_i));
endmodule

// File: tb/tb_buzzer_tone_gen.sv
`timescale 1ns/100ps
module tb_buzzer_tone_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1, buz_en_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, port_data_i = 1'b0;
  logic [1:0] freq_sel_i = 2'd0, mode_sel_i = 2'd0;
  logic pin_o, shot_done_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  // behavioural reference state
  int m_t, m_g10, m_g1, m_freq, m_mode;
  bit m_run, m_done;

  always #2.5 clk = ~clk;

  buzzer_tone_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .buz_en_i(buz_en_i),
    .freq_sel_i(freq_sel_i), .mode_sel_i(mode_sel_i), .start_i(start_i),
    .stop_i(stop_i), .port_data_i(port_data_i), .pin_o(pin_o),
    .shot_done_o(shot_done_o)
  );

  function automatic int per_of(int f);
    int p[4] = '{100, 75, 50, 25};
    return p[f];
  endfunction

  function automatic bit model_pin();
    bit g;
    if (!buz_en_i) return port_data_i;
    case (m_mode)
      2: g = (m_g10 < 3750);
      3: g = (m_g1 < 37500) && (m_g10 < 3750);
      default: g = 1'b1;
    endcase
    return m_run && g && (m_t >= (per_of(m_freq) + 1) / 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = 0; m_g10 = 0; m_g1 = 0; m_freq = 0; m_mode = 0; m_run = 0; m_done = 0;
    end else begin
      bit chg, rs, adv, fin;
      chg = (int'(freq_sel_i) != m_freq) || (int'(mode_sel_i) != m_mode);
      rs  = start_i || stop_i || chg || !buz_en_i;
      adv = tick_i && m_run && buz_en_i && !rs;
      fin = adv && m_mode == 1 && m_g1 == 7499;
      if (rs || fin) begin
        m_t = 0; m_g10 = 0; m_g1 = 0;
      end else if (adv) begin
        m_t = (m_t + 1) % per_of(m_freq);
        m_g10 = (m_g10 + 1) % 7500;
        m_g1 = (m_g1 + 1) % 75000;
      end
      if (stop_i) m_run = 0; else if (start_i) m_run = 1; else if (fin) m_run = 0;
      if (start_i || chg) m_done = 0; else if (fin) m_done = 1;
      m_freq = int'(freq_sel_i);
      m_mode = int'(mode_sel_i);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_on && rst_n) begin
      checks++;
      if (pin_o !== model_pin() || shot_done_o !== m_done) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s cycle %0d: pin=%b exp %b done=%b exp %b", cur_req, cycles,
                   pin_o, model_pin(), shot_done_o, m_done);
      end
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles, expected under 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_edge();
    @(negedge clk); #1;
  endtask

  task automatic pulse(bit s, bit p);
    drive_edge(); start_i = s; stop_i = p;
    drive_edge(); start_i = 0; stop_i = 0;
  endtask

  initial begin
    wait_cyc(4);
    #1 rst_n = 1'b1;
    model_on = 1'b1;
    // R1: reset state, pin follows port
    wait_cyc(1);
    chk("R1 done after reset", shot_done_o, 1'b0);
    drive_edge(); port_data_i = 1'b1;
    wait_cyc(1);
    chk("R1 pin follows port", pin_o, 1'b1);

    // R8: enable low, engine held
    cur_req = "R8";
    pulse(1, 0);
    for (int i = 0; i < 40; i++) begin drive_edge(); port_data_i = i[0]; end
    wait_cyc(1);
    chk("R8 pin follows port while disabled", pin_o, port_data_i);
    drive_edge(); buz_en_i = 1'b1;
    wait_cyc(1);
    chk("R8 tone starts low after enable", pin_o, 1'b0);

    // R2/R3: every pitch in steady mode
    for (int f = 0; f < 4; f++) begin
      cur_req = (f == 0) ? "R3" : "R2";
      drive_edge(); freq_sel_i = 2'(f);
      wait_cyc(420);
    end

    // R11: sparse ticks
    cur_req = "R11";
    drive_edge(); freq_sel_i = 2'd1;
    for (int i = 0; i < 300; i++) begin drive_edge(); tick_i = (i % 3 == 0); end
    drive_edge(); tick_i = 1'b0;
    wait_cyc(2);
    begin
      logic held;
      held = pin_o;
      wait_cyc(20);
      chk("R11 pin holds without ticks", pin_o, held);
    end
    drive_edge(); tick_i = 1'b1;

    // R7: change pitch while tone high
    cur_req = "R7";
    while (pin_o !== 1'b1) @(negedge clk);
    #1 freq_sel_i = 2'd2;
    wait_cyc(1);
    chk("R7 pin low after pitch change", pin_o, 1'b0);
    wait_cyc(100);

    // R4: single burst
    cur_req = "R4";
    drive_edge(); mode_sel_i = 2'd1;
    pulse(1, 0);
    wait_cyc(7600);
    chk("R4 done after burst", shot_done_o, 1'b1);
    chk("R4 pin low after burst", pin_o, 1'b0);

    // R10: start clears done; config change clears done
    cur_req = "R10";
    pulse(1, 0);
    chk("R10 start clears done", shot_done_o, 1'b0);
    wait_cyc(7600);
    chk("R10 done set again", shot_done_o, 1'b1);
    drive_edge(); freq_sel_i = 2'd3;
    wait_cyc(1);
    chk("R10 pitch change clears done", shot_done_o, 1'b0);

    // R5: 10 Hz pattern
    cur_req = "R5";
    drive_edge(); mode_sel_i = 2'd2;
    pulse(1, 0);
    wait_cyc(16000);

    // R6: nested 1 Hz pattern, one full period plus margin
    cur_req = "R6";
    drive_edge(); mode_sel_i = 2'd3;
    pulse(1, 0);
    wait_cyc(38000);
    chk("R6 silent half-second", pin_o, 1'b0);
    wait_cyc(38500);

    // R9: stop halts; simultaneous start and stop
    cur_req = "R9";
    drive_edge(); mode_sel_i = 2'd0;
    pulse(1, 0);
    wait_cyc(60);
    pulse(0, 1);
    wait_cyc(200);
    chk("R9 pin low after stop", pin_o, 1'b0);
    pulse(1, 1);
    wait_cyc(200);
    chk("R9 stop wins over start", pin_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule